// File: doc/BRIEF.md
# Status Register Write Guard

This unit keeps the write-enable latch and the retained protection bits of a small serial-memory status register. It decides, for every completed command, whether an array byte write or a status-register write may go ahead. The serial front end delivers one-cycle strobes when a command frame closes properly. These are enable, disable, array write and status write. It also supplies the target array address, the level of the external protect pin, the busy flag of the internal write engine and the data byte for a status write. The unit answers with the status byte, with combinational permits for the current inputs and with registered accept pulses that start the write engine.

The array is split into four equal regions by the two most significant address bits. A two-bit region-lock code covers no region, the top region, the upper half or the whole array. The external pin can only lock the status register, and only while the pin-enable bit is set. A retained bit's power-up value comes from a parameter; the latch always powers up clear.

Top module: `sr_guard_top`

## Requirements
- R1: The status byte reads bit 7 = pin-enable bit, bits 6..4 = 0, bit 3 = lock code high bit, bit 2 = lock code low bit, bit 1 = write-enable latch, bit 0 = busy input (same cycle). After reset the latch is 0 and the retained bits hold their parameter values.
- R2: An enable strobe sets the latch and a disable strobe clears it, from the next cycle on, whatever the pin-enable bit, the pin and the lock code are. If both come together, the disable wins.
- R3: With the latch at 0, both permits are 0, no accept pulse is produced and no retained bit changes.
- R4: Lock code 00 locks nothing, 01 locks 0x600..0x7FF, 10 locks 0x400..0x7FF and 11 locks 0x000..0x7FF (11-bit address). An array write to a locked address is refused.
- R5: A status write is refused only when the latch is 1, the pin-enable bit is 1 and the pin is low. The pin and the pin-enable bit never affect the array permit.
- R6: An accepted status write loads only bits 7, 3 and 2 from the data byte and clears the latch. statusWrGo is high for exactly the next cycle.
- R7: An accepted array write clears the latch. arrayWrGo is high for exactly the next cycle.
- R8: A refused write leaves the latch and the retained bits unchanged and gives no accept pulse.
- R9: While the busy input is 1, both permits are 0 and every strobe is ignored.
- R10: A write strobe in the same cycle as an enable strobe is judged against the latch value held before that cycle. An accepted write's clear takes priority over the enable.
- R11: A status write is judged only in its strobe cycle. Lowering the pin afterwards does not undo it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset (power-up) |
| cmdEnable | input | 1 | Completed enable command strobe |
| cmdDisable | input | 1 | Completed disable command strobe |
| cmdStatusWr | input | 1 | Completed status-write command strobe |
| cmdArrayWr | input | 1 | Completed array-write command strobe |
| arrayAddr | input | ADDR_W | Target array byte address |
| wpLevel | input | 1 | External protect pin level (1 = high) |
| wipBusy | input | 1 | Internal write engine busy |
| statusData | input | 8 | Data byte of a status write |
| statusByte | output | 8 | Status byte for a status read |
| arrayPermit | output | 1 | Array write would be accepted now |
| statusPermit | output | 1 | Status write would be accepted now |
| arrayWrGo | output | 1 | Accepted array write pulse |
| statusWrGo | output | 1 | Accepted status write pulse |

## Verification
Directed sequences walk through every lock code at region edges such as 0x3FF/0x400 and 0x5FF/0x600. They also cover the full latch, pin-enable and pin matrix, which separates array locking from pin locking. Coinciding strobes (enable with disable, enable with a write) show the priority order and that a write uses the old latch. Busy cycles carrying strobes show that nothing slips through. Random command mixes with random pin, address and data then confirm that state evolves like a reference model built from the requirements.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;
  localparam int unsigned STAT_W = 8;

  typedef struct packed {
    logic welSet;
    logic welClr;
    logic loadStatus;
  } guardStrobe_t;
endpackage

// File: rtl/sr_guard_ctrl.sv
module sr_guard_ctrl
  import sr_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdEnable,
  input  logic         cmdDisable,
  input  logic         cmdStatusWr,
  input  logic         cmdArrayWr,
  input  logic         wipBusy,
  input  logic         wpLevel,
  input  logic         welQ,
  input  logic         wpenQ,
  input  logic         protHit,
  output guardStrobe_t strobe,
  output logic         arrayPermit,
  output logic         statusPermit,
  output logic         arrayWrGo,
  output logic         statusWrGo
);
  logic hwLock;
  logic arrayAccept;
  logic statusAccept;

  // Pin lock only bites when the retained pin-enable bit is set
  assign hwLock       = wpenQ & ~wpLevel;
  assign arrayPermit  = ~wipBusy & welQ & ~protHit;
  assign statusPermit = ~wipBusy & welQ & ~hwLock;
  assign arrayAccept  = cmdArrayWr & arrayPermit;
  assign statusAccept = cmdStatusWr & statusPermit;

  always_comb begin
    strobe.welSet     = ~wipBusy & cmdEnable;
    strobe.welClr     = ~wipBusy & (cmdDisable | arrayAccept | statusAccept);
    strobe.loadStatus = statusAccept;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arrayWrGo  <= 1'b0;
      statusWrGo <= 1'b0;
    end else begin
      arrayWrGo  <= arrayAccept;
      statusWrGo <= statusAccept;
    end
  end

  p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    wipBusy |=> (!arrayWrGo && !statusWrGo));

  p_go_needs_latch_r3: assert property (@(posedge clk) disable iff (!rstN)
    (arrayWrGo || statusWrGo) |-> $past(welQ));
endmodule

// File: rtl/sr_guard_dp.sv
module sr_guard_dp
  import sr_guard_pkg::*;
#(
  parameter logic       WPEN_INIT = 1'b0,
  parameter logic [1:0] BP_INIT   = 2'b00
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardStrobe_t      strobe,
  input  logic [STAT_W-1:0] statusData,
  input  logic [1:0]        regionSel,
  input  logic              wipBusy,
  output logic              welQ,
  output logic              wpenQ,
  output logic [1:0]        bpQ,
  output logic              protHit,
  output logic [STAT_W-1:0] statusByte
);
  localparam int unsigned REGIONS = 4;

  logic [REGIONS-1:0] regionLocked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welQ  <= 1'b0;
      wpenQ <= WPEN_INIT;
      bpQ   <= BP_INIT;
    end else begin
      if (strobe.welClr)      welQ <= 1'b0;
      else if (strobe.welSet) welQ <= 1'b1;
      if (strobe.loadStatus) begin
        wpenQ <= statusData[7];
        bpQ   <= statusData[3:2];
      end
    end
  end

  // Per-region lock decode from the two-bit lock code
  for (genvar q = 0; q < REGIONS; q++) begin : g_region
    localparam bit UPPER_HALF  = (q >= 2);
    localparam bit TOP_QUARTER = (q == 3);
    assign regionLocked[q] = (bpQ == 2'b11)
                           | ((bpQ == 2'b10) & UPPER_HALF)
                           | ((bpQ == 2'b01) & TOP_QUARTER);
  end

  assign protHit    = regionLocked[regionSel];
  assign statusByte = {wpenQ, 3'b000, bpQ, welQ, wipBusy};

  p_status_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadStatus |=> $stable({wpenQ, bpQ}));

  p_clear_wins_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.welClr |=> !welQ);
endmodule

// File: rtl/sr_guard_top.sv
module sr_guard_top
  import sr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W    = 11,
  parameter logic        WPEN_INIT = 1'b0,
  parameter logic [1:0]  BP_INIT   = 2'b00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdEnable,
  input  logic              cmdDisable,
  input  logic              cmdStatusWr,
  input  logic              cmdArrayWr,
  input  logic [ADDR_W-1:0] arrayAddr,
  input  logic              wpLevel,
  input  logic              wipBusy,
  input  logic [STAT_W-1:0] statusData,
  output logic [STAT_W-1:0] statusByte,
  output logic              arrayPermit,
  output logic              statusPermit,
  output logic              arrayWrGo,
  output logic              statusWrGo
);
  localparam int unsigned SEL_LSB = ADDR_W - 2;

  guardStrobe_t strobe;
  logic         welQ;
  logic         wpenQ;
  logic [1:0]   bpQ;
  logic         protHit;

  sr_guard_ctrl u_ctrl (
    .clk, .rstN, .cmdEnable, .cmdDisable, .cmdStatusWr, .cmdArrayWr,
    .wipBusy, .wpLevel, .welQ, .wpenQ, .protHit, .strobe,
    .arrayPermit, .statusPermit, .arrayWrGo, .statusWrGo
  );

  sr_guard_dp #(.WPEN_INIT(WPEN_INIT), .BP_INIT(BP_INIT)) u_dp (
    .clk, .rstN, .strobe, .statusData,
    .regionSel(arrayAddr[SEL_LSB +: 2]),
    .wipBusy, .welQ, .wpenQ, .bpQ, .protHit, .statusByte
  );

  p_pin_guard_r5: assert property (@(posedge clk) disable iff (!rstN)
    statusWrGo |-> !$past(wpenQ && !wpLevel));

  p_range_guard_r4: assert property (@(posedge clk) disable iff (!rstN)
    arrayWrGo |-> !$past(protHit));

  p_write_drops_latch_r7: assert property (@(posedge clk) disable iff (!rstN)
    (arrayWrGo || statusWrGo) |-> !welQ);

  p_enable_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdEnable && !cmdDisable && !wipBusy && !cmdArrayWr && !cmdStatusWr) |=> welQ);
endmodule

// File: tb/sr_guard_top_tb.sv
module sr_guard_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        en = 1'b0, dis = 1'b0, wr = 1'b0, sw = 1'b0;
  logic [10:0] addr = '0;
  logic        wp = 1'b1, wip = 1'b0;
  logic [7:0]  data = '0;
  logic [7:0]  statusByte;
  logic        arrayPermit, statusPermit, arrayWrGo, statusWrGo;

  int checks = 0;
  int errors = 0;

  // reference state
  bit       mWel = 1'b0;
  bit       mWpen = 1'b0;
  bit [1:0] mBp = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  sr_guard_top u_dut (
    .clk, .rstN, .cmdEnable(en), .cmdDisable(dis), .cmdStatusWr(sw),
    .cmdArrayWr(wr), .arrayAddr(addr), .wpLevel(wp), .wipBusy(wip),
    .statusData(data), .statusByte, .arrayPermit, .statusPermit,
    .arrayWrGo, .statusWrGo
  );

  function automatic bit regionLocked(bit [1:0] bp, logic [10:0] a);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return a >= 11'h600;
      2'b10:   return a >= 11'h400;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic step(bit e, bit d, bit w, bit s, logic [10:0] a, bit p,
                      bit busy, logic [7:0] dat, string tag);
    bit expA, expS, accA, accS;
    en = e; dis = d; wr = w; sw = s; addr = a; wp = p; wip = busy; data = dat;
    #1;
    expA = !busy && mWel && !regionLocked(mBp, a);
    expS = !busy && mWel && !(mWpen && !p);
    check(arrayPermit == expA, {tag, " array permit"}, arrayPermit, expA);
    check(statusPermit == expS, {tag, " status permit"}, statusPermit, expS);
    accA = w && expA;
    accS = s && expS;
    if (!busy) begin
      if (accS) begin
        mWpen = dat[7];
        mBp   = dat[3:2];
      end
      if (d || accA || accS) mWel = 1'b0;
      else if (e)            mWel = 1'b1;
    end
    @(negedge clk);
    check(arrayWrGo == accA, {tag, " arrayWrGo"}, arrayWrGo, accA);
    check(statusWrGo == accS, {tag, " statusWrGo"}, statusWrGo, accS);
    check(statusByte == {mWpen, 3'b000, mBp, mWel, busy}, {tag, " status byte"},
          statusByte, {mWpen, 3'b000, mBp, mWel, busy});
  endtask

  task automatic idle(bit p, bit busy, string tag);
    step(0, 0, 0, 0, 11'h000, p, busy, 8'h00, tag);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1: reset state, latch clear, retained bits at defaults (0)
    check(statusByte == 8'h00, "R1 reset byte", statusByte, 8'h00);
    check(!arrayPermit && !statusPermit, "R1 reset permits",
          {arrayPermit, statusPermit}, 0);
    rstN = 1'b1;
    @(negedge clk);

    idle(1, 1, "R1 busy bit");
    // R3: writes refused with latch clear
    step(0, 0, 1, 0, 11'h010, 1, 0, 8'h00, "R3 array");
    step(0, 0, 0, 1, 11'h000, 1, 0, 8'hFF, "R3 status");
    // R2: enable sets latch
    step(1, 0, 0, 0, 11'h000, 1, 0, 8'h00, "R2 enable");
    // R6: status write loads bits 7,3,2 only -> 0x8C
    step(0, 0, 0, 1, 11'h000, 1, 0, 8'hFC, "R6 load");
    check(statusByte == 8'h8C, "R6 unused zero", statusByte, 8'h8C);
    // R4/R8: all locked, refused, latch stays
    step(1, 0, 0, 0, 11'h000, 1, 0, 8'h00, "R2 enable");
    step(0, 0, 1, 0, 11'h000, 1, 0, 8'h00, "R8 locked array");
    // R5: pin low with pin-enable set blocks status write
    step(0, 0, 0, 1, 11'h000, 0, 0, 8'h00, "R5 pin lock");
    // R5/R6: pin high allows, lock code 01
    step(0, 0, 0, 1, 11'h000, 1, 0, 8'h84, "R5 pin high");
    // R11: pin drops afterwards, state kept
    idle(0, 0, "R11 after");
    // R4: top region boundaries
    step(1, 0, 0, 0, 11'h000, 0, 0, 8'h00, "R2 pin low enable");
    step(0, 0, 0, 0, 11'h600, 0, 0, 8'h00, "R4 600 locked");
    step(0, 0, 1, 0, 11'h5FF, 0, 0, 8'h00, "R7 5FF write");
    check(statusByte[1] == 1'b0, "R7 latch cleared", statusByte[1], 0);
    step(1, 0, 0, 0, 11'h000, 0, 0, 8'h00, "R2 enable");
    step(0, 0, 1, 0, 11'h600, 0, 0, 8'h00, "R4 600 refused");
    // R5: array permit untouched by pin lock
    step(0, 0, 1, 0, 11'h000, 0, 0, 8'h00, "R5 array under pin lock");
    // lock code 10 (pin high needed)
    step(1, 0, 0, 0, 11'h000, 1, 0, 8'h00, "R2 enable");
    step(0, 0, 0, 1, 11'h000, 1, 0, 8'h08, "R6 code 10");
    step(1, 0, 0, 0, 11'h3FF, 1, 0, 8'h00, "R4 3FF");
    step(0, 0, 0, 0, 11'h400, 1, 0, 8'h00, "R4 400");
    // R9: busy ignores everything
    step(0, 1, 0, 0, 11'h000, 1, 1, 8'h00, "R9 busy disable");
    step(0, 0, 1, 1, 11'h000, 1, 1, 8'hFF, "R9 busy writes");
    step(0, 1, 0, 0, 11'h000, 1, 0, 8'h00, "R2 disable");
    step(1, 0, 0, 0, 11'h000, 1, 1, 8'h00, "R9 busy enable");
    // R10: enable with write in the same cycle, latch was 0
    step(1, 0, 1, 0, 11'h000, 1, 0, 8'h00, "R10 old latch");
    check(statusByte[1] == 1'b1, "R10 latch set", statusByte[1], 1);
    // R10: accepted write clear beats enable
    step(1, 0, 1, 0, 11'h100, 1, 0, 8'h00, "R10 clear wins");
    // R2: disable wins over enable, pin lock irrelevant
    step(1, 0, 0, 0, 11'h000, 1, 0, 8'h00, "R2 enable");
    step(1, 1, 0, 0, 11'h000, 0, 0, 8'h00, "R2 both");

    for (int i = 0; i < 800; i++) begin
      int op = $urandom % 10;
      step(op == 1 || op == 2 || op == 7 || op == 8, op == 3,
           op == 4 || op == 7, op == 5 || op == 8, 11'($urandom),
           1'($urandom), ($urandom % 8) == 0, 8'($urandom), "RND");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule